// File: doc/BRIEF.md
# Integer ALU with Overflow Trap

This block is the purely combinational integer arithmetic and logic unit of a 32-bit load/store processor. In each cycle it takes a first operand from the register file and either a second register operand or a 16-bit immediate field. It also takes an operation code, and from these it produces a result word, a register write-enable and a request to raise an overflow trap.

The block covers four kinds of operation: two's-complement addition and subtraction, the bitwise operations AND, OR, XOR and NOR, and a less-than test that writes 1 or 0. The arithmetic and the less-than test each come in a signed and an unsigned flavour. Only signed addition and signed subtraction can trap. When they overflow, the write-enable drops so the destination register keeps its old value. The unsigned flavours wrap modulo 2^32 and never trap.

Immediate operands are widened inside the block. The width of the extension follows the operation: logical operations fill the upper bits with zeros, while arithmetic and compare operations copy the sign bit into them.

Top module: `int_alu`

## Requirements
- R1: With opSel 0 (signed add) or 1 (unsigned add), result equals first operand plus second operand, modulo 2^32.
- R2: With opSel 2 (signed subtract) or 3 (unsigned subtract), result equals first operand minus second operand, modulo 2^32.
- R3: Signed add and signed subtract assert trapReq and deassert wrEn exactly when the true signed result lies outside -2^31 .. 2^31-1.
- R4: Unsigned add and unsigned subtract never assert trapReq and always assert wrEn, wrapping silently.
- R5: opSel 4, 5, 6 and 7 give bitwise AND, OR, XOR and NOR of the two operands respectively.
- R6: opSel 8 writes 1 when the first operand is less than the second as signed numbers, else 0.
- R7: opSel 9 writes 1 when the first operand is less than the second as unsigned numbers, else 0.
- R8: When useImm is 1 the second operand is the 16-bit imm widened to 32 bits: zero-extended for opSel 4 to 7, sign-extended for all other codes, including opSel 9.
- R9: opSel codes 10 to 15 are unassigned: result is 0, wrEn is 0 and trapReq is 0.
- R10: Every assigned code other than an overflowing signed add or subtract gives wrEn 1 and trapReq 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| opA | input | 32 | First operand |
| opB | input | 32 | Second register operand |
| imm | input | 16 | Immediate field, widened per R8 |
| useImm | input | 1 | Select immediate instead of opB as second operand |
| opSel | input | 4 | Operation code (see R1 to R9) |
| result | output | 32 | Operation result |
| wrEn | output | 1 | Destination register write-enable |
| trapReq | output | 1 | Overflow trap request |

## Verification
Computing the result and raising the trap happen together. A signed add or subtract that overflows must still produce the wrapped sum while, in the same evaluation, dropping wrEn and raising trapReq. Directed vectors therefore place operands at the edges of the signed range: 0x7FFFFFFF + 1, 0x80000000 - 1, and immediates whose sign extension pushes a sum across the limit. Each vector is also repeated under the unsigned code to show the trap staying quiet. On every clock, a reference model built on 64-bit integer arithmetic judges all three outputs together, so a trap raised on the wrong vector, or a write left enabled beside a trap, shows up on the very vector that caused it.

// File: rtl/alu_pkg.sv
package alu_pkg;
  localparam int OP_W = 4;

  typedef enum logic [OP_W-1:0] {
    OP_ADD  = 4'd0,
    OP_ADDU = 4'd1,
    OP_SUB  = 4'd2,
    OP_SUBU = 4'd3,
    OP_AND  = 4'd4,
    OP_OR   = 4'd5,
    OP_XOR  = 4'd6,
    OP_NOR  = 4'd7,
    OP_SLT  = 4'd8,
    OP_SLTU = 4'd9
  } opCode_e;

  typedef enum logic [2:0] {
    RES_ZERO,
    RES_ARITH,
    RES_AND,
    RES_OR,
    RES_XOR,
    RES_NOR,
    RES_SET
  } resSel_e;

  typedef struct packed {
    logic    doSub;
    logic    trapEn;
    logic    signCmp;
    logic    zeroExt;
    logic    valid;
    resSel_e resSel;
  } ctrlStrobe_t;
endpackage

// File: rtl/alu_ctrl.sv
module alu_ctrl
  import alu_pkg::*;
(
  input  logic [OP_W-1:0] opSel,
  input  logic            ovfRaw,
  output ctrlStrobe_t     strobe,
  output logic            wrEn,
  output logic            trapReq
);
  always_comb begin
    strobe = '{doSub: 1'b0, trapEn: 1'b0, signCmp: 1'b0, zeroExt: 1'b0,
               valid: 1'b1, resSel: RES_ARITH};
    case (opSel)
      OP_ADD:  strobe.trapEn = 1'b1;
      OP_ADDU: ;
      OP_SUB:  begin strobe.doSub = 1'b1; strobe.trapEn = 1'b1; end
      OP_SUBU: strobe.doSub = 1'b1;
      OP_AND:  begin strobe.resSel = RES_AND; strobe.zeroExt = 1'b1; end
      OP_OR:   begin strobe.resSel = RES_OR;  strobe.zeroExt = 1'b1; end
      OP_XOR:  begin strobe.resSel = RES_XOR; strobe.zeroExt = 1'b1; end
      OP_NOR:  begin strobe.resSel = RES_NOR; strobe.zeroExt = 1'b1; end
      OP_SLT:  begin strobe.resSel = RES_SET; strobe.signCmp = 1'b1; end
      OP_SLTU: strobe.resSel = RES_SET;
      default: begin strobe.resSel = RES_ZERO; strobe.valid = 1'b0; end
    endcase
  end

  assign trapReq = strobe.trapEn & ovfRaw;
  assign wrEn    = strobe.valid & ~trapReq;
endmodule

// File: rtl/alu_datapath.sv
module alu_datapath
  import alu_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int IMM_W  = 16
) (
  input  ctrlStrobe_t       strobe,
  input  logic [DATA_W-1:0] opA,
  input  logic [DATA_W-1:0] opB,
  input  logic [IMM_W-1:0]  imm,
  input  logic              useImm,
  output logic [DATA_W-1:0] result,
  output logic              ovfRaw
);
  localparam int MSB   = DATA_W - 1;
  localparam int EXT_W = DATA_W - IMM_W;

  logic [DATA_W-1:0] immExt;
  logic [DATA_W-1:0] bEff;
  logic [DATA_W-1:0] bAdd;
  logic [DATA_W-1:0] sum;
  logic              lessS;
  logic              lessU;
  logic              setBit;

  generate
    if (EXT_W > 0) begin : g_ext
      assign immExt = strobe.zeroExt ? {{EXT_W{1'b0}}, imm}
                                     : {{EXT_W{imm[IMM_W-1]}}, imm};
    end else begin : g_noext
      assign immExt = imm[DATA_W-1:0];
    end
  endgenerate

  assign bEff  = useImm ? immExt : opB;
  assign bAdd  = strobe.doSub ? ~bEff : bEff;
  assign sum   = opA + bAdd + {{(DATA_W-1){1'b0}}, strobe.doSub};
  assign ovfRaw = (opA[MSB] == bAdd[MSB]) && (sum[MSB] != opA[MSB]);

  assign lessU  = opA < bEff;
  assign lessS  = (opA[MSB] != bEff[MSB]) ? opA[MSB] : lessU;
  assign setBit = strobe.signCmp ? lessS : lessU;

  always_comb begin
    case (strobe.resSel)
      RES_ARITH: result = sum;
      RES_AND:   result = opA & bEff;
      RES_OR:    result = opA | bEff;
      RES_XOR:   result = opA ^ bEff;
      RES_NOR:   result = ~(opA | bEff);
      RES_SET:   result = {{(DATA_W-1){1'b0}}, setBit};
      default:   result = '0;
    endcase
  end
endmodule

// File: rtl/int_alu.sv
module int_alu
  import alu_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int IMM_W  = 16
) (
  input  logic [DATA_W-1:0] opA,
  input  logic [DATA_W-1:0] opB,
  input  logic [IMM_W-1:0]  imm,
  input  logic              useImm,
  input  logic [OP_W-1:0]   opSel,
  output logic [DATA_W-1:0] result,
  output logic              wrEn,
  output logic              trapReq
);
  ctrlStrobe_t strobe;
  logic        ovfRaw;

  alu_ctrl u_ctrl (
    .opSel   (opSel),
    .ovfRaw  (ovfRaw),
    .strobe  (strobe),
    .wrEn    (wrEn),
    .trapReq (trapReq)
  );

  alu_datapath #(.DATA_W(DATA_W), .IMM_W(IMM_W)) u_dp (
    .strobe (strobe),
    .opA    (opA),
    .opB    (opB),
    .imm    (imm),
    .useImm (useImm),
    .result (result),
    .ovfRaw (ovfRaw)
  );
endmodule

// File: rtl/int_alu_chk.sv
module int_alu_chk
  import alu_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int IMM_W  = 16
) (
  input logic [DATA_W-1:0] opA,
  input logic [DATA_W-1:0] opB,
  input logic [IMM_W-1:0]  imm,
  input logic              useImm,
  input logic [OP_W-1:0]   opSel,
  input logic [DATA_W-1:0] result,
  input logic              wrEn,
  input logic              trapReq
);
  localparam int MSB = DATA_W - 1;

  always_comb begin
    // R3
    trap_blocks_write_chk: assert (!(trapReq && wrEn));
    // R4
    no_overflow_chk: assert (!((opSel == OP_ADDU || opSel == OP_SUBU) && trapReq));
    // R6
    set_is_bit_chk: assert (!((opSel == OP_SLT || opSel == OP_SLTU) && result[MSB:1] != '0));
    // R9
    unassigned_quiet_chk: assert (!(opSel > OP_SLTU && (wrEn || trapReq || result != '0)));
    // R3
    add_trap_sign_chk: assert (!(opSel == OP_ADD && !useImm && trapReq &&
                                 !(opA[MSB] == opB[MSB] && result[MSB] != opA[MSB])));
  end
endmodule

bind int_alu int_alu_chk #(.DATA_W(DATA_W), .IMM_W(IMM_W)) u_chk (
  .opA(opA), .opB(opB), .imm(imm), .useImm(useImm), .opSel(opSel),
  .result(result), .wrEn(wrEn), .trapReq(trapReq)
);

// File: tb/test_int_alu.sv
module test_int_alu;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [31:0] opA = '0;
  logic [31:0] opB = '0;
  logic [15:0] imm = '0;
  logic        useImm = 1'b0;
  logic [3:0]  opSel = '0;
  logic [31:0] result;
  logic        wrEn;
  logic        trapReq;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  int_alu i_int_alu (
    .opA(opA), .opB(opB), .imm(imm), .useImm(useImm), .opSel(opSel),
    .result(result), .wrEn(wrEn), .trapReq(trapReq)
  );

  // Behavioural reference: 64-bit integer arithmetic, no bit tricks.
  task automatic model(input logic [3:0] op, input logic ui, input logic [31:0] a,
                       input logic [31:0] b, input logic [15:0] im,
                       output logic [31:0] r, output logic w, output logic t);
    longint sa, sb, ua, ub, full;
    logic [31:0] bv;
    if (ui) begin
      if (op >= 4 && op <= 7) bv = {16'h0, im};
      else bv = 32'($signed(im));
    end else bv = b;
    sa = longint'($signed(a)); sb = longint'($signed(bv));
    ua = longint'(a);          ub = longint'(bv);
    r = 0; w = 1; t = 0;
    case (op)
      0, 1: begin full = sa + sb; r = 32'(full);
              if (op == 0 && (full > 64'sd2147483647 || full < -64'sd2147483648)) begin t = 1; w = 0; end
            end
      2, 3: begin full = sa - sb; r = 32'(full);
              if (op == 2 && (full > 64'sd2147483647 || full < -64'sd2147483648)) begin t = 1; w = 0; end
            end
      4: r = a & bv;
      5: r = a | bv;
      6: r = a ^ bv;
      7: r = ~(a | bv);
      8: r = (sa < sb) ? 1 : 0;
      9: r = (ua < ub) ? 1 : 0;
      default: begin r = 0; w = 0; end
    endcase
  endtask

  task automatic apply(input string req, input logic [3:0] op, input logic ui,
                       input logic [31:0] a, input logic [31:0] b, input logic [15:0] im);
    logic [31:0] er; logic ew, et;
    @(posedge clk); #1;
    opSel = op; useImm = ui; opA = a; opB = b; imm = im;
    model(op, ui, a, b, im, er, ew, et);
    @(negedge clk);
    checks++;
    if (result !== er || wrEn !== ew || trapReq !== et) begin
      errors++;
      $display("FAIL %s op=%0d imm=%0b a=%h b=%h i=%h: got r=%h w=%b t=%b exp r=%h w=%b t=%b",
               req, op, ui, a, b, im, result, wrEn, trapReq, er, ew, et);
    end
  endtask

  initial begin
    repeat (3) @(posedge clk);
    rst = 1'b0;
    // reset state: all-zero inputs, add of zeros
    apply("R1", 0, 0, 0, 0, 0);
    apply("R1", 0, 0, 32'h1234_5678, 32'h1111_1111, 0);
    apply("R1", 1, 0, 32'hFFFF_FFFF, 32'h2, 0);
    apply("R2", 2, 0, 32'h10, 32'h30, 0);
    apply("R2", 3, 0, 32'h0, 32'h1, 0);
    apply("R3", 0, 0, 32'h7FFF_FFFF, 32'h1, 0);
    apply("R3", 0, 0, 32'h8000_0000, 32'h8000_0000, 0);
    apply("R3", 2, 0, 32'h8000_0000, 32'h1, 0);
    apply("R3", 2, 0, 32'h7FFF_FFFF, 32'hFFFF_FFFF, 0);
    apply("R3", 0, 1, 32'h8000_0000, 0, 16'hFFFF);
    apply("R3", 0, 1, 32'h7FFF_FFF0, 0, 16'h0010);
    apply("R4", 1, 0, 32'h7FFF_FFFF, 32'h1, 0);
    apply("R4", 3, 0, 32'h8000_0000, 32'h1, 0);
    apply("R4", 1, 1, 32'h7FFF_FFFF, 0, 16'h0001);
    apply("R5", 4, 0, 32'hF0F0_AAAA, 32'hFF00_5555, 0);
    apply("R5", 5, 0, 32'hF0F0_AAAA, 32'h0F00_5555, 0);
    apply("R5", 6, 0, 32'hF0F0_AAAA, 32'hFFFF_0000, 0);
    apply("R5", 7, 0, 32'h0000_00FF, 32'hF000_0000, 0);
    apply("R6", 8, 0, 32'hFFFF_FFFF, 32'h1, 0);
    apply("R6", 8, 0, 32'h5, 32'h5, 0);
    apply("R6", 8, 0, 32'h7FFF_FFFF, 32'h8000_0000, 0);
    apply("R7", 9, 0, 32'hFFFF_FFFF, 32'h1, 0);
    apply("R7", 9, 0, 32'h1, 32'hFFFF_FFFF, 0);
    apply("R8", 4, 1, 32'hFFFF_FFFF, 0, 16'h8001);
    apply("R8", 5, 1, 32'h0, 0, 16'hF000);
    apply("R8", 6, 1, 32'hFFFF_0000, 0, 16'hFFFF);
    apply("R8", 1, 1, 32'h10, 0, 16'hFFFF);
    apply("R8", 9, 1, 32'h7000_0000, 0, 16'h8000);
    apply("R8", 8, 1, 32'h0, 0, 16'hFFFF);
    for (int c = 10; c < 16; c++) apply("R9", 4'(c), 0, 32'hDEAD_BEEF, 32'h1234_5678, 16'hFFFF);
    for (int n = 0; n < 400; n++)
      apply("R10", 4'($urandom_range(0, 15)), 1'($urandom), $urandom, $urandom, 16'($urandom));
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (100000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog: got timeout exp completion");
      end
    join_any
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule